// File: doc/BRIEF.md
# Software-managed translation buffer with probe

This block is a fully associative address translation table whose contents software loads and maintains directly; no hardware refill takes place. Each slot holds a virtual page-pair tag, a per-slot page-size mask, an address space identifier, a global flag and two physical frame descriptors. One descriptor serves the even page of the pair and the other serves the odd page. Each descriptor carries a frame number, a 3-bit cacheability code, a dirty flag and a valid flag.

A combinational lookup port translates a virtual address for a given address space identifier. It reports hit or miss, the slot that matched, and the chosen frame's number, cacheability and dirty flag. It also raises an uncacheable, strictly ordered flag when the address falls in a fixed window.

A single command port lets software write a slot by index, read a slot back as packed words, probe for the slot that owns a tag, flush the whole table, and step a round-robin replacement pointer. Read and probe results appear on registered outputs one cycle after the command.

Top module: `swtlb`

## Requirements
- R1: After synchronous active-high reset, every slot is empty. Lookups miss, the read words are zero, the probe result is a miss (pr_miss=1, pr_idx all ones) and nxt_idx is 0.
- R2: A slot matches a tag when the tag agrees with the stored tag on every bit not set in the slot's mask, and either the slot's global flag is set or the ASID equals the stored one. The mask covers tag bits 15:0; tag bits 18:16 always compare.
- R3: The tag of a 32-bit address is bits 31:13. The odd/even selector is page-number bit n, where the page number is address bits 31:12 and n is the number of consecutive set mask bits counted from bit 0. A selector of 1 picks frame 1 and a selector of 0 picks frame 0. A lookup hits only if the chosen frame is valid, and it then returns that frame's number, cacheability and dirty flag with the slot index.
- R4: When several slots match, both the lookup and the probe report the lowest index.
- R5: Probe (op_code 3) takes its tag from op_hi bits 29:11 and its ASID from op_hi bits 7:0. One cycle later it shows pr_miss=0 and the slot index, or pr_miss=1 with pr_idx all ones. The chosen frame's valid flag plays no part in a probe.
- R6: Read (op_code 2) loads four words one cycle later. rd_hi holds the tag at bits 29:11 and the ASID at bits 7:0. rd_lo0 and rd_lo1 each hold frame number at bits 25:6, cacheability at 5:3, dirty at 2, valid at 1 and the global flag at 0. rd_mask holds the mask at bits 26:11. All other bits are zero, and an index of 16 or more reads as all zeros.
- R7: Write (op_code 1) loads the slot op_index from op_hi, op_lo0, op_lo1 and op_mask, laid out as in R6; the global flag is taken from op_lo0 bit 0. A write to an index of 16 or more changes no slot.
- R8: Flush (op_code 4) clears every field of every slot and sets nxt_idx to 0.
- R9: Advance (op_code 5) steps nxt_idx by one, wrapping from 15 to 0. No other command changes nxt_idx, except flush.
- R10: lk_uncached is 1 exactly when lk_va AND 0xA0000000 equals 0xA0000000.
- R11: A slot with both valid flags clear matches neither a lookup nor a probe. Op_code 0, and op_codes 6 and 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Command: 0 none, 1 write, 2 read, 3 probe, 4 flush, 5 advance |
| op_index | input | 5 | Slot index for write and read |
| op_hi | input | 32 | Tag and ASID word for write and probe |
| op_lo0 | input | 32 | Even frame word for write |
| op_lo1 | input | 32 | Odd frame word for write |
| op_mask | input | 32 | Mask word for write |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 4 | Matching slot |
| lk_pfn | output | 20 | Chosen frame number |
| lk_cach | output | 3 | Chosen frame cacheability |
| lk_dirty | output | 1 | Chosen frame dirty flag |
| lk_uncached | output | 1 | Address in the uncacheable, strictly ordered window |
| rd_hi | output | 32 | Read-back tag and ASID word |
| rd_lo0 | output | 32 | Read-back even frame word |
| rd_lo1 | output | 32 | Read-back odd frame word |
| rd_mask | output | 32 | Read-back mask word |
| pr_miss | output | 1 | Probe found no slot |
| pr_idx | output | 5 | Probe result index, all ones on miss |
| nxt_idx | output | 4 | Round-robin replacement pointer |

## Verification
A corrupted slot field shows up as a wrong read-back word in the cycle after a read of that slot. It also shows up at once on the lookup outputs as a false hit, a false miss or a wrong frame for any address that lands on that tag. A fault in the priority or mask logic surfaces as a wrong index on the lookup port in the same cycle, or on the probe output one cycle after a probe. A pointer fault appears on nxt_idx in the cycle after an advance or flush. The bench therefore compares every lookup output and every registered output against a behavioural table model on every clock, under directed and randomised command streams.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W    = 32;
    localparam int PAGE_SH = 12;
    localparam int VPN_W   = VA_W - PAGE_SH;
    localparam int VPN2_W  = VPN_W - 1;
    localparam int ASID_W  = 8;
    localparam int PFN_W   = 20;
    localparam int MASK_W  = 16;
    localparam int CACH_W  = 3;
    localparam int WORD_W  = 32;
    localparam int TAG_SH  = 11;
    localparam int PFN_SH  = 6;
    localparam int CACH_SH = 3;
    localparam logic [VA_W-1:0] UNC_WIN = 32'hA000_0000;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_READ    = 3'd2,
        OP_PROBE   = 3'd3,
        OP_FLUSH   = 3'd4,
        OP_ADVANCE = 3'd5
    } op_e;

    typedef struct packed {
        logic [PFN_W-1:0]  pfn;
        logic [CACH_W-1:0] cach;
        logic              dirty;
        logic              valid;
    } frame_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [MASK_W-1:0] mask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        frame_t            f0;
        frame_t            f1;
    } entry_t;

    function automatic logic [WORD_W-1:0] pack_lo(input frame_t f, input logic g);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PFN_SH +: PFN_W]   = f.pfn;
        w[CACH_SH +: CACH_W] = f.cach;
        w[2]                 = f.dirty;
        w[1]                 = f.valid;
        w[0]                 = g;
        return w;
    endfunction

    function automatic frame_t unpack_lo(input logic [WORD_W-1:0] w);
        frame_t f;
        f.pfn   = w[PFN_SH +: PFN_W];
        f.cach  = w[CACH_SH +: CACH_W];
        f.dirty = w[2];
        f.valid = w[1];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] pack_hi(input logic [VPN2_W-1:0] v,
                                                  input logic [ASID_W-1:0] a);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TAG_SH +: VPN2_W] = v;
        w[ASID_W-1:0]       = a;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] pack_mask(input logic [MASK_W-1:0] m);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TAG_SH +: MASK_W] = m;
        return w;
    endfunction

    function automatic logic tag_hit(input entry_t e,
                                     input logic [VPN2_W-1:0] v,
                                     input logic [ASID_W-1:0] a);
        logic [VPN2_W-1:0] care;
        care = ~VPN2_W'(e.mask);
        return (((v ^ e.vpn2) & care) == '0) && (e.glob || (a == e.asid));
    endfunction

    function automatic logic odd_pick(input logic [VPN_W-1:0] vpn,
                                      input logic [MASK_W-1:0] m);
        logic [MASK_W:0] ext;
        logic            done;
        logic            r;
        ext  = {1'b0, m};
        done = 1'b0;
        r    = vpn[0];
        for (int i = 0; i <= MASK_W; i++) begin
            if (!done && !ext[i]) begin
                r    = vpn[i];
                done = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic slot_live(input entry_t e);
        return e.f0.valid | e.f1.valid;
    endfunction

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear,
    input  entry_t            wdata,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VPN2_W-1:0] pr_vpn2,
    input  logic [ASID_W-1:0] pr_asid,
    output entry_t            ent,
    output logic              lk_match,
    output frame_t            lk_frame,
    output logic              pr_match
);

    logic live;
    logic odd;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ent <= '0;
        end else if (load) begin
            ent <= wdata;
        end
    end

    always_comb begin
        live     = slot_live(ent);
        odd      = odd_pick(lk_vpn, ent.mask);
        lk_frame = odd ? ent.f1 : ent.f0;
        lk_match = live && tag_hit(ent, lk_vpn[VPN_W-1:1], lk_asid) && lk_frame.valid;
        pr_match = live && tag_hit(ent, pr_vpn2, pr_asid);
    end

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/swtlb.sv
module swtlb
    import tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int OPI_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         op_code,
    input  logic [OPI_W-1:0]   op_index,
    input  logic [WORD_W-1:0]  op_hi,
    input  logic [WORD_W-1:0]  op_lo0,
    input  logic [WORD_W-1:0]  op_lo1,
    input  logic [WORD_W-1:0]  op_mask,
    input  logic [VA_W-1:0]    lk_va,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic               lk_hit,
    output logic [IDX_W-1:0]   lk_idx,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [CACH_W-1:0]  lk_cach,
    output logic               lk_dirty,
    output logic               lk_uncached,
    output logic [WORD_W-1:0]  rd_hi,
    output logic [WORD_W-1:0]  rd_lo0,
    output logic [WORD_W-1:0]  rd_lo1,
    output logic [WORD_W-1:0]  rd_mask,
    output logic               pr_miss,
    output logic [OPI_W-1:0]   pr_idx,
    output logic [IDX_W-1:0]   nxt_idx
);

    op_e               op;
    logic              in_range;
    logic [IDX_W-1:0]  slot;
    logic              flush_now;
    entry_t            wdata;
    logic [VPN_W-1:0]  lk_vpn;
    logic [VPN2_W-1:0] pr_vpn2;
    logic [ASID_W-1:0] pr_asid;

    entry_t            ents      [N_ENT];
    frame_t            lk_frames [N_ENT];
    logic [N_ENT-1:0]  lk_vec;
    logic [N_ENT-1:0]  pr_vec;
    logic              pr_any;
    logic [IDX_W-1:0]  pr_first;

    assign op        = op_e'(op_code);
    assign in_range  = (op_index < OPI_W'(N_ENT));
    assign slot      = op_index[IDX_W-1:0];
    assign flush_now = (op == OP_FLUSH);
    assign lk_vpn    = lk_va[VA_W-1:PAGE_SH];
    assign pr_vpn2   = op_hi[TAG_SH +: VPN2_W];
    assign pr_asid   = op_hi[ASID_W-1:0];

    always_comb begin
        wdata.vpn2 = op_hi[TAG_SH +: VPN2_W];
        wdata.asid = op_hi[ASID_W-1:0];
        wdata.mask = op_mask[TAG_SH +: MASK_W];
        wdata.glob = op_lo0[0];
        wdata.f0   = unpack_lo(op_lo0);
        wdata.f1   = unpack_lo(op_lo1);
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        logic load_g;
        assign load_g = (op == OP_WRITE) && in_range && (slot == IDX_W'(g));
        tlb_entry u_ent (
            .clk      (clk),
            .rst      (rst),
            .load     (load_g),
            .clear    (flush_now),
            .wdata    (wdata),
            .lk_vpn   (lk_vpn),
            .lk_asid  (lk_asid),
            .pr_vpn2  (pr_vpn2),
            .pr_asid  (pr_asid),
            .ent      (ents[g]),
            .lk_match (lk_vec[g]),
            .lk_frame (lk_frames[g]),
            .pr_match (pr_vec[g])
        );
    end

    tlb_first_hit #(.N(N_ENT), .W(IDX_W)) u_lk_pick (
        .req (lk_vec),
        .any (lk_hit),
        .idx (lk_idx)
    );

    tlb_first_hit #(.N(N_ENT), .W(IDX_W)) u_pr_pick (
        .req (pr_vec),
        .any (pr_any),
        .idx (pr_first)
    );

    always_comb begin
        lk_pfn      = lk_frames[lk_idx].pfn;
        lk_cach     = lk_frames[lk_idx].cach;
        lk_dirty    = lk_frames[lk_idx].dirty;
        lk_uncached = ((lk_va & UNC_WIN) == UNC_WIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hi   <= '0;
            rd_lo0  <= '0;
            rd_lo1  <= '0;
            rd_mask <= '0;
            pr_miss <= 1'b1;
            pr_idx  <= '1;
            nxt_idx <= '0;
        end else begin
            case (op)
                OP_READ: begin
                    if (in_range) begin
                        rd_hi   <= pack_hi(ents[slot].vpn2, ents[slot].asid);
                        rd_lo0  <= pack_lo(ents[slot].f0, ents[slot].glob);
                        rd_lo1  <= pack_lo(ents[slot].f1, ents[slot].glob);
                        rd_mask <= pack_mask(ents[slot].mask);
                    end else begin
                        rd_hi   <= '0;
                        rd_lo0  <= '0;
                        rd_lo1  <= '0;
                        rd_mask <= '0;
                    end
                end
                OP_PROBE: begin
                    pr_miss <= !pr_any;
                    pr_idx  <= pr_any ? {1'b0, pr_first} : '1;
                end
                OP_FLUSH: begin
                    nxt_idx <= '0;
                end
                OP_ADVANCE: begin
                    nxt_idx <= (nxt_idx == IDX_W'(N_ENT - 1)) ? '0 : nxt_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int N_ENT = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int OPI_W = IDX_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       op_code,
    input logic [31:0]      lk_va,
    input logic             lk_hit,
    input logic             lk_uncached,
    input logic [31:0]      rd_hi,
    input logic             pr_miss,
    input logic [OPI_W-1:0] pr_idx,
    input logic [IDX_W-1:0] nxt_idx
);

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_hit && pr_miss && nxt_idx == '0 && rd_hi == '0));

    p_probe_code_r5: assert property (@(posedge clk) disable iff (rst)
        pr_miss |-> (pr_idx == '1));

    p_probe_range_r5: assert property (@(posedge clk) disable iff (rst)
        !pr_miss |-> (pr_idx < OPI_W'(N_ENT)));

    p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_code) != 3'd2) |-> $stable(rd_hi));

    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_code) == 3'd4) |-> (nxt_idx == '0 && !lk_hit));

    p_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_code) == 3'd5 && $past(nxt_idx) == IDX_W'(N_ENT - 1))
        |-> (nxt_idx == '0));

    p_step_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_code) == 3'd5 && $past(nxt_idx) != IDX_W'(N_ENT - 1))
        |-> (nxt_idx == $past(nxt_idx) + 1'b1));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_code) != 3'd5 && $past(op_code) != 3'd4)
        |-> $stable(nxt_idx));

    p_unc_in_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_va[31:28] == 4'hB || lk_va[31:28] == 4'hF) |-> lk_uncached);

    p_unc_out_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_va[31:28] < 4'hA) |-> !lk_uncached);

endmodule

bind swtlb tlb_chk #(.N_ENT(N_ENT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_code     (op_code),
    .lk_va       (lk_va),
    .lk_hit      (lk_hit),
    .lk_uncached (lk_uncached),
    .rd_hi       (rd_hi),
    .pr_miss     (pr_miss),
    .pr_idx      (pr_idx),
    .nxt_idx     (nxt_idx)
);

// File: tb/sim_swtlb.sv
`timescale 1ns/1ps
module sim_swtlb;

    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_code = '0;
    logic [4:0]  op_index = '0;
    logic [31:0] op_hi = '0, op_lo0 = '0, op_lo1 = '0, op_mask = '0;
    logic [31:0] lk_va = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_dirty, lk_uncached, pr_miss;
    logic [3:0]  lk_idx, nxt_idx;
    logic [19:0] lk_pfn;
    logic [2:0]  lk_cach;
    logic [31:0] rd_hi, rd_lo0, rd_lo1, rd_mask;
    logic [4:0]  pr_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    swtlb u0 (
        .clk(clk), .rst(rst), .op_code(op_code), .op_index(op_index),
        .op_hi(op_hi), .op_lo0(op_lo0), .op_lo1(op_lo1), .op_mask(op_mask),
        .lk_va(lk_va), .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_pfn(lk_pfn), .lk_cach(lk_cach), .lk_dirty(lk_dirty),
        .lk_uncached(lk_uncached), .rd_hi(rd_hi), .rd_lo0(rd_lo0),
        .rd_lo1(rd_lo1), .rd_mask(rd_mask), .pr_miss(pr_miss),
        .pr_idx(pr_idx), .nxt_idx(nxt_idx)
    );

    // behavioural table model
    logic [18:0] m_vpn2 [NE];
    logic [15:0] m_mask [NE];
    logic [7:0]  m_asid [NE];
    logic        m_g    [NE];
    logic [19:0] m_pfn  [2][NE];
    logic [2:0]  m_c    [2][NE];
    logic        m_d    [2][NE];
    logic        m_v    [2][NE];
    logic [31:0] e_rd [4];
    logic        e_pmiss;
    logic [4:0]  e_pidx;
    int          e_nxt;

    task automatic mdl_clear();
        for (int i = 0; i < NE; i++) begin
            m_vpn2[i] = 0; m_mask[i] = 0; m_asid[i] = 0; m_g[i] = 0;
            for (int k = 0; k < 2; k++) begin
                m_pfn[k][i] = 0; m_c[k][i] = 0; m_d[k][i] = 0; m_v[k][i] = 0;
            end
        end
    endtask

    function automatic bit same_page(int i, logic [18:0] v2, logic [7:0] a);
        for (int b = 0; b < 19; b++) begin
            if ((b >= 16 || !m_mask[i][b]) && v2[b] != m_vpn2[i][b]) return 0;
        end
        return m_g[i] || (a == m_asid[i]);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] op, input logic [4:0] idx,
                       input logic [31:0] hi, input logic [31:0] lo0,
                       input logic [31:0] lo1, input logic [31:0] msk,
                       input logic [31:0] va, input logic [7:0] asid,
                       input string tag);
        logic        eh;
        int          ei;
        logic [19:0] ep;
        logic [2:0]  ec;
        logic        ed;
        logic [19:0] vpn;
        op_code = op; op_index = idx; op_hi = hi; op_lo0 = lo0; op_lo1 = lo1;
        op_mask = msk; lk_va = va; lk_asid = asid;
        #1;
        // lookup model (R2, R3, R4, R11)
        vpn = va[31:12];
        eh = 0; ei = 0; ep = 0; ec = 0; ed = 0;
        for (int i = NE - 1; i >= 0; i--) begin
            int n;
            int s;
            n = 0;
            while (n < 16 && m_mask[i][n]) n++;
            s = vpn[n] ? 1 : 0;
            if ((m_v[0][i] || m_v[1][i]) && same_page(i, vpn[19:1], asid) && m_v[s][i]) begin
                eh = 1; ei = i; ep = m_pfn[s][i]; ec = m_c[s][i]; ed = m_d[s][i];
            end
        end
        chk(tag, "lk_hit", 32'(lk_hit), 32'(eh));
        if (eh) begin
            chk(tag, "lk_idx", 32'(lk_idx), 32'(ei));
            chk(tag, "lk_pfn", 32'(lk_pfn), 32'(ep));
            chk(tag, "lk_cach", 32'(lk_cach), 32'(ec));
            chk(tag, "lk_dirty", 32'(lk_dirty), 32'(ed));
        end
        chk("R10", "lk_uncached", 32'(lk_uncached),
            32'((va & 32'hA000_0000) == 32'hA000_0000));
        @(posedge clk);
        #1;
        case (op)
            3'd1: if (idx < NE) begin
                m_vpn2[idx] = hi[29:11]; m_asid[idx] = hi[7:0];
                m_mask[idx] = msk[26:11]; m_g[idx] = lo0[0];
                m_pfn[0][idx] = lo0[25:6]; m_c[0][idx] = lo0[5:3];
                m_d[0][idx] = lo0[2]; m_v[0][idx] = lo0[1];
                m_pfn[1][idx] = lo1[25:6]; m_c[1][idx] = lo1[5:3];
                m_d[1][idx] = lo1[2]; m_v[1][idx] = lo1[1];
            end
            3'd2: begin
                if (idx < NE) begin
                    e_rd[0] = ({13'b0, m_vpn2[idx]} << 11) | {24'b0, m_asid[idx]};
                    e_rd[1] = ({12'b0, m_pfn[0][idx]} << 6) | ({29'b0, m_c[0][idx]} << 3)
                              | (32'(m_d[0][idx]) << 2) | (32'(m_v[0][idx]) << 1) | 32'(m_g[idx]);
                    e_rd[2] = ({12'b0, m_pfn[1][idx]} << 6) | ({29'b0, m_c[1][idx]} << 3)
                              | (32'(m_d[1][idx]) << 2) | (32'(m_v[1][idx]) << 1) | 32'(m_g[idx]);
                    e_rd[3] = {16'b0, m_mask[idx]} << 11;
                end else begin
                    for (int k = 0; k < 4; k++) e_rd[k] = 0;
                end
            end
            3'd3: begin
                e_pmiss = 1; e_pidx = 5'h1F;
                for (int i = NE - 1; i >= 0; i--) begin
                    if ((m_v[0][i] || m_v[1][i]) && same_page(i, hi[29:11], hi[7:0])) begin
                        e_pmiss = 0; e_pidx = 5'(i);
                    end
                end
            end
            3'd4: begin mdl_clear(); e_nxt = 0; end
            3'd5: e_nxt = (e_nxt + 1) % NE;
            default: ;
        endcase
        @(negedge clk);
        chk(tag, "rd_hi", rd_hi, e_rd[0]);
        chk(tag, "rd_lo0", rd_lo0, e_rd[1]);
        chk(tag, "rd_lo1", rd_lo1, e_rd[2]);
        chk(tag, "rd_mask", rd_mask, e_rd[3]);
        chk(tag, "pr_miss", 32'(pr_miss), 32'(e_pmiss));
        chk(tag, "pr_idx", 32'(pr_idx), 32'(e_pidx));
        chk(tag, "nxt_idx", 32'(nxt_idx), 32'(e_nxt));
    endtask

    function automatic logic [31:0] hiw(logic [18:0] v2, logic [7:0] a);
        return ({13'b0, v2} << 11) | {24'b0, a};
    endfunction
    function automatic logic [31:0] low(logic [19:0] p, logic [2:0] c, logic d,
                                        logic v, logic g);
        return ({12'b0, p} << 6) | ({29'b0, c} << 3) | (32'(d) << 2) | (32'(v) << 1) | 32'(g);
    endfunction
    function automatic logic [31:0] vaw(logic [18:0] v2, int selpos, logic odd);
        logic [19:0] vpn;
        vpn = {v2, 1'b0};
        vpn[selpos] = odd;
        return {vpn, 12'h345};
    endfunction

    task automatic wr(int idx, logic [31:0] hi, logic [31:0] l0, logic [31:0] l1,
                      logic [15:0] m, string tag);
        cyc(3'd1, 5'(idx), hi, l0, l1, {16'b0, m} << 11, 32'h0, 8'h0, tag);
    endtask
    task automatic look(logic [31:0] va, logic [7:0] a, string tag);
        cyc(3'd0, 5'd0, 32'h0, 32'h0, 32'h0, 32'h0, va, a, tag);
    endtask
    task automatic probe(logic [31:0] hi, string tag);
        cyc(3'd3, 5'd0, hi, 32'h0, 32'h0, 32'h0, 32'h0, 8'h0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        mdl_clear();
        for (int k = 0; k < 4; k++) e_rd[k] = 0;
        e_pmiss = 1; e_pidx = 5'h1F; e_nxt = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        look(vaw(19'h0, 0, 0), 8'h0, "R1");
        cyc(3'd2, 5'd3, 0, 0, 0, 0, 32'h0, 8'h0, "R1");
        // R2/R3: plain 4K pair with ASID 5
        wr(0, hiw(19'h01234, 8'h05), low(20'hAAAAA, 3'd2, 1, 1, 0),
           low(20'hBBBBB, 3'd5, 0, 1, 0), 16'h0, "R7");
        look(vaw(19'h01234, 0, 0), 8'h05, "R3");
        look(vaw(19'h01234, 0, 1), 8'h05, "R3");
        look(vaw(19'h01234, 0, 1), 8'h06, "R2");
        look(vaw(19'h01235, 0, 1), 8'h05, "R2");
        // R2/R3: global entry with mask 3, odd frame invalid
        wr(1, hiw(19'h00100, 8'h09), low(20'h11111, 3'd3, 0, 1, 1),
           low(20'h22222, 3'd1, 1, 0, 1), 16'h0003, "R7");
        look(vaw(19'h00102, 2, 0), 8'h77, "R2");
        look(vaw(19'h00101, 2, 1), 8'h77, "R3");
        look(vaw(19'h00104, 2, 0), 8'h09, "R2");
        // R4: duplicate tag in slots 3 and 2, lowest wins
        wr(3, hiw(19'h05555, 8'h01), low(20'h33333, 0, 0, 1, 0), low(20'h33334, 0, 0, 1, 0), 16'h0, "R7");
        wr(2, hiw(19'h05555, 8'h01), low(20'h44444, 0, 1, 1, 0), low(20'h44445, 0, 1, 1, 0), 16'h0, "R7");
        look(vaw(19'h05555, 0, 0), 8'h01, "R4");
        probe(hiw(19'h05555, 8'h01), "R4");
        // R5: probe hit ignoring frame valid, and miss
        probe(hiw(19'h00101, 8'h42), "R5");
        probe(hiw(19'h07777, 8'h01), "R5");
        // R11: slot with no valid frame never matches
        wr(4, hiw(19'h06666, 8'h02), low(20'h1, 0, 0, 0, 1), low(20'h2, 0, 0, 0, 0), 16'h0, "R11");
        look(vaw(19'h06666, 0, 0), 8'h02, "R11");
        probe(hiw(19'h06666, 8'h02), "R11");
        cyc(3'd7, 5'd0, hiw(19'h1, 8'h1), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
            vaw(19'h01234, 0, 0), 8'h05, "R11");
        // R7: out-of-range write ignored; R6: read back all slots and beyond
        wr(20, hiw(19'h01234, 8'h05), low(20'hDEAD0, 7, 1, 1, 1), low(20'hDEAD1, 7, 1, 1, 1), 16'hFFFF, "R7");
        wr(16, hiw(19'h05555, 8'h01), low(20'hDEAD2, 7, 1, 1, 1), low(20'hDEAD3, 7, 1, 1, 1), 16'h0, "R7");
        look(vaw(19'h01234, 0, 0), 8'h05, "R7");
        for (int i = 0; i < 18; i++)
            cyc(3'd2, 5'(i), 0, 0, 0, 0, 32'h0, 8'h0, "R6");
        cyc(3'd2, 5'd31, 0, 0, 0, 0, 32'h0, 8'h0, "R6");
        // R9: advance through a wrap
        for (int i = 0; i < 18; i++)
            cyc(3'd5, 5'd0, 0, 0, 0, 0, 32'h0, 8'h0, "R9");
        // R10: window edges
        look(32'hA000_0000, 8'h0, "R10");
        look(32'hBFFF_FFFF, 8'h0, "R10");
        look(32'h8000_0000, 8'h0, "R10");
        look(32'h2000_0000, 8'h0, "R10");
        look(32'hE123_4000, 8'h0, "R10");
        // R8: flush
        cyc(3'd4, 5'd0, 0, 0, 0, 0, vaw(19'h01234, 0, 0), 8'h05, "R8");
        look(vaw(19'h01234, 0, 1), 8'h05, "R8");
        cyc(3'd2, 5'd0, 0, 0, 0, 0, 32'h0, 8'h0, "R8");
        probe(hiw(19'h05555, 8'h01), "R8");
        // randomised mix
        for (int t = 0; t < 600; t++) begin
            logic [2:0]  op;
            logic [3:0]  hi4;
            logic [15:0] mk;
            logic [31:0] va;
            int r;
            r = $urandom % 20;
            op = (r < 6) ? 3'd1 : (r < 9) ? 3'd2 : (r < 12) ? 3'd3 :
                 (r < 13) ? 3'd4 : (r < 15) ? 3'd5 : 3'd0;
            hi4 = ($urandom % 2) ? 4'hA : 4'h0;
            case ($urandom % 4)
                0: mk = 16'h0000;
                1: mk = 16'h0001;
                2: mk = 16'h0003;
                default: mk = 16'h000F;
            endcase
            va = {hi4, 11'h0, 5'($urandom), 12'($urandom)};
            cyc(op, 5'($urandom % 20),
                hiw({hi4, 11'h0, 4'($urandom)}, 8'($urandom % 3)),
                low(20'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)),
                low(20'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)),
                {16'b0, mk} << 11, va, 8'($urandom % 3), "R2");
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule